// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Status

This block sits beside a real-time clock's time-keeping counters and turns their activity into interrupt status. Each time the counters finish an update, it compares the current seconds, minutes and hours against three alarm bytes. Any alarm byte with its two most significant bits both set is treated as "don't care" for its field. The block also records a periodic tick coming from an external divider.

Three sticky flags are kept in an 8-bit status byte: periodic, alarm and update-ended. A summary bit in the status byte rises whenever a set flag has its enable bit on. That summary bit also drives the interrupt request line. Software clears the flags by reading the status byte, and the read is signalled to this block by a one-cycle strobe. An event that arrives in the same cycle as the read is kept.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm byte whose bits 7 and 6 are both 1 matches any value of its time field. An alarm byte with only one of those two bits set is compared exactly.
- R2: In the cycle after an update-done strobe, status bit 5 (alarm) becomes 1 if seconds, minutes and hours all match their alarm bytes. If any field mismatches, bit 5 is not set.
- R3: The alarm comparison only takes effect on an update-done strobe. Matching fields without a strobe never set bit 5.
- R4: Status bit 4 (update-ended) becomes 1 in the cycle after every update-done strobe.
- R5: Status bit 6 (periodic) becomes 1 in the cycle after a periodic tick strobe.
- R6: Status bit 7 is 1 exactly when some flag is set and its enable is on. Enable input bit 6 gates the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bit 7 follows an enable change in the same cycle.
- R7: While the read strobe is high, the status byte still shows the flags held before the read. From the next cycle on, all flags read 0.
- R8: A flag event in the same cycle as a read strobe leaves that flag set after the read.
- R9: Status bits 3 to 0 always read 0.
- R10: The interrupt output is active high and always equals status bit 7.
- R11: After reset, the status byte is 0x00 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hr_i | input | 8 | Current hours |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| upd_done_i | input | 1 | One-cycle strobe: time fields have just advanced |
| per_tick_i | input | 1 | One-cycle periodic tick strobe |
| ctl_en_i | input | 3 (6:4) | Enables: 6 periodic, 5 alarm, 4 update-ended |
| stat_rd_i | input | 1 | One-cycle strobe: status byte is being read |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to produce is a read that collides with a new event. In that cycle the read must still return the old byte, and the new flag must survive the clear. The stimulus drives a read strobe and a periodic tick in the same cycle. It then inspects the byte during the read cycle and again in the following cycle. Wildcard handling is also reached deliberately, by contrasting an hours alarm of 0xC0 against one of 0x80 with the same time values.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, status bit positions and flag type for the
// RTC alarm/interrupt block. Assumes an 8-bit status byte.
package rtc_irq_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_IRQ  = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_ALM  = 5;
    localparam int BIT_UPD  = 4;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } irq_flags_t;
endpackage

// File: rtl/rtc_field_match.sv
// Compares one time field against its alarm byte. An alarm byte whose two
// top bits are both set is a wildcard. Assumes FIELD_W >= 2.
module rtc_field_match #(
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] time_i,
    input  logic [FIELD_W-1:0] alarm_i,
    output logic               hit_o
);
    localparam int TOP = FIELD_W - 1;

    // Wildcard or exact equality.
    always_comb begin
        hit_o = (alarm_i[TOP -: 2] == 2'b11) || (alarm_i == time_i);
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Combines NUM_FIELDS per-field matchers into one alarm-match signal.
// Assumes fields are packed with field 0 in the lowest bits.
module rtc_alarm_cmp #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_i,
    output logic                          match_o
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_field_match #(.FIELD_W(FIELD_W)) u_fm (
            .time_i  (time_i[g*FIELD_W +: FIELD_W]),
            .alarm_i (alarm_i[g*FIELD_W +: FIELD_W]),
            .hit_o   (hit[g])
        );
    end

    // All fields must match.
    always_comb match_o = &hit;
endmodule

// File: rtl/rtc_irq_status.sv
// Sticky interrupt flags with clear-on-read and a gated summary bit.
// Assumes strobes are single-cycle; events coinciding with a read win.
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_done_i,
    input  logic              alarm_match_i,
    input  logic              per_tick_i,
    input  logic              rd_i,
    input  logic [2:0]        en_i,      // {per, alm, upd}
    output logic [STAT_W-1:0] stat_o
);
    irq_flags_t flags_q, set_evt;

    // Events raised this cycle.
    always_comb begin
        set_evt.per = per_tick_i;
        set_evt.alm = upd_done_i && alarm_match_i;
        set_evt.upd = upd_done_i;
    end

    // Flag register: read clears, new events always stick.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (rd_i)  flags_q <= set_evt;
        else            flags_q <= flags_q | set_evt;
    end

    // Status byte assembly with gated summary bit.
    always_comb begin
        stat_o          = '0;
        stat_o[BIT_PER] = flags_q.per;
        stat_o[BIT_ALM] = flags_q.alm;
        stat_o[BIT_UPD] = flags_q.upd;
        stat_o[BIT_IRQ] = |(flags_q & en_i);
    end

    a_r2_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done_i && alarm_match_i) |=> stat_o[BIT_ALM]);
    a_r4_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_i |=> stat_o[BIT_UPD]);
    a_r5_periodic_sets: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick_i |=> stat_o[BIT_PER]);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !upd_done_i && !per_tick_i) |=> (stat_o[6:4] == 3'b000));
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !upd_done_i && !per_tick_i) |=> $stable(stat_o[6:4]));
endmodule

// File: rtl/rtc_alarm_irq.sv
// Top: alarm comparison over seconds/minutes/hours plus interrupt status.
// Assumes time fields are already advanced when upd_done_i pulses.
module rtc_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] sec_i,
    input  logic [FIELD_W-1:0] min_i,
    input  logic [FIELD_W-1:0] hr_i,
    input  logic [FIELD_W-1:0] alm_sec_i,
    input  logic [FIELD_W-1:0] alm_min_i,
    input  logic [FIELD_W-1:0] alm_hr_i,
    input  logic               upd_done_i,
    input  logic               per_tick_i,
    input  logic [6:4]         ctl_en_i,
    input  logic               stat_rd_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic               irq_o
);
    localparam int NF = 3;

    logic [NF*FIELD_W-1:0] time_bus, alarm_bus;
    logic                  match;

    // Pack fields for the comparator.
    always_comb begin
        time_bus  = {hr_i, min_i, sec_i};
        alarm_bus = {alm_hr_i, alm_min_i, alm_sec_i};
    end

    rtc_alarm_cmp #(.FIELD_W(FIELD_W), .NUM_FIELDS(NF)) u_cmp (
        .time_i  (time_bus),
        .alarm_i (alarm_bus),
        .match_o (match)
    );

    rtc_irq_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_done_i    (upd_done_i),
        .alarm_match_i (match),
        .per_tick_i    (per_tick_i),
        .rd_i          (stat_rd_i),
        .en_i          (ctl_en_i),
        .stat_o        (stat_o)
    );

    // Interrupt line mirrors the summary bit.
    always_comb irq_o = stat_o[BIT_IRQ];

    a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[6:4] == 3'b000) |-> !irq_o);
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] sec_i = 0, min_i = 0, hr_i = 0;
    logic [7:0] alm_sec_i = 0, alm_min_i = 0, alm_hr_i = 0;
    logic       upd_done_i = 0, per_tick_i = 0, stat_rd_i = 0;
    logic [6:4] ctl_en_i = 0;
    logic [7:0] stat_o;
    logic       irq_o;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    rtc_alarm_irq dut_i (.*);

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of the given strobes, then sample after the edge.
    task automatic cyc(bit upd, bit tick, bit rd);
        upd_done_i = upd; per_tick_i = tick; stat_rd_i = rd;
        @(negedge clk);
        upd_done_i = 0; per_tick_i = 0; stat_rd_i = 0;
    endtask

    task automatic clear_all();
        cyc(0, 0, 1);
    endtask

    task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
        hr_i = h; min_i = m; sec_i = s;
    endtask

    task automatic set_alarm(logic [7:0] h, logic [7:0] m, logic [7:0] s);
        alm_hr_i = h; alm_min_i = m; alm_sec_i = s;
    endtask

    task automatic t_reset();
        check("R11 status after reset", stat_o, 8'h00);
        check("R11 irq after reset", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_update_and_read();
        ctl_en_i = 3'b000;
        set_time(8'h01, 8'h02, 8'h03); set_alarm(8'h09, 8'h09, 8'h09);
        cyc(1, 0, 0);
        check("R4 update flag", stat_o, 8'h10);
        stat_rd_i = 1;
        #1;
        check("R7 value during read", stat_o, 8'h10);
        @(negedge clk); stat_rd_i = 0;
        check("R7 cleared after read", stat_o, 8'h00);
    endtask

    task automatic t_alarm();
        set_time(8'h12, 8'h34, 8'h56); set_alarm(8'h12, 8'h34, 8'h56);
        cyc(1, 0, 0);
        check("R2 exact alarm match", stat_o, 8'h30);
        clear_all();
        set_alarm(8'h12, 8'h35, 8'h56);
        cyc(1, 0, 0);
        check("R2 minute mismatch", stat_o, 8'h10);
        clear_all();
    endtask

    task automatic t_wildcard();
        set_time(8'h07, 8'h00, 8'h00); set_alarm(8'hC0, 8'h00, 8'h00);
        cyc(1, 0, 0);
        check("R1 wildcard hours", stat_o, 8'h30);
        clear_all();
        set_alarm(8'h80, 8'h00, 8'h00);
        cyc(1, 0, 0);
        check("R1 single top bit not wildcard", stat_o, 8'h10);
        clear_all();
        set_alarm(8'hFF, 8'hC5, 8'hE1);
        cyc(1, 0, 0);
        check("R1 all wildcards", stat_o, 8'h30);
        clear_all();
    endtask

    task automatic t_no_strobe();
        set_time(8'h05, 8'h05, 8'h05); set_alarm(8'h05, 8'h05, 8'h05);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R3 match without strobe", stat_o, 8'h00);
    endtask

    task automatic t_periodic_enables();
        set_alarm(8'h09, 8'h09, 8'h09);
        cyc(0, 1, 0);
        check("R5 periodic flag", stat_o, 8'h40);
        check("R10 irq low when disabled", {7'b0, irq_o}, 8'h00);
        ctl_en_i = 3'b100; #1;
        check("R6 periodic enabled", stat_o, 8'hC0);
        check("R10 irq high", {7'b0, irq_o}, 8'h01);
        ctl_en_i = 3'b011; #1;
        check("R6 other enables only", stat_o, 8'h40);
        cyc(1, 0, 0);
        check("R6 update enable", stat_o, 8'hD0);
        ctl_en_i = 3'b010; #1;
        check("R6 alarm enable, alarm clear", stat_o, 8'h50);
        ctl_en_i = 3'b000;
        clear_all();
    endtask

    task automatic t_coincide();
        cyc(1, 0, 0);
        stat_rd_i = 1; per_tick_i = 1;
        #1;
        check("R8 read cycle shows old", stat_o, 8'h10);
        @(negedge clk); stat_rd_i = 0; per_tick_i = 0;
        check("R8 tick survives read", stat_o, 8'h40);
        clear_all();
    endtask

    task automatic t_low_bits();
        ctl_en_i = 3'b111;
        set_time(8'h00, 8'h00, 8'h00); set_alarm(8'hC0, 8'hC0, 8'hC0);
        cyc(1, 1, 0);
        check("R9 low bits zero, all set", stat_o, 8'hF0);
        check("R9 low nibble", {4'b0, stat_o[3:0]}, 8'h00);
        ctl_en_i = 3'b000;
        clear_all();
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_update_and_read();
        t_alarm();
        t_wildcard();
        t_no_strobe();
        t_periodic_enables();
        t_coincide();
        t_low_bits();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule